// File: doc/BRIEF.md
# Epoch-Tagged Fetch Redirect Unit

This block is the control that lets an in-order pipeline keep fetching past unresolved branches and then recover from a wrong guess. The fetch side always guesses that a branch is not taken, so it steps the program counter by one instruction width. It issues each address to instruction memory and, in the same cycle, hands decode a tag. The tag holds the fetch address, the guessed successor address and a one-bit epoch.

The execute side receives every resolved instruction back with its tag and the successor address that execution actually computed. An instruction whose epoch differs from the execute epoch came from a path that has already been abandoned. It is dropped, and it is not allowed to change any state. An instruction whose epoch matches is committed. If its real successor differs from the guess, execute flips its epoch and places the correct address into a one-entry redirect queue. On the next cycle, fetch takes the address from that queue, loads it into the program counter and flips its own epoch. No kill wires run backwards through the stages.

Top module: `fetch_redirect_unit`

## Requirements
- R1: Without a redirect, each issued fetch address equals the previous issued address plus 4 bytes, starting from address 0 after reset.
- R2: Every issued fetch carries, on `fd_pred_pc`, its own address plus 4, and on `fd_epoch` the fetch epoch that was current when it was issued.
- R3: A resolution whose epoch bit differs from the execute epoch raises `res_drop` one cycle later. It does not raise `res_commit` or `res_mispredict`, and it never redirects fetch, even if its two addresses differ.
- R4: A resolution with a matching epoch and `res_next_pc` different from `res_pred_pc` raises `res_mispredict` one cycle later and flips the execute epoch. A matching resolution with equal addresses does neither.
- R5: When the redirect queue holds an entry, fetch removes it on the next edge and issues nothing on that edge. The first issue after that is at the redirect target, with the fetch epoch inverted.
- R6: Reset is synchronous and active-high. It clears the program counter, both epochs, the redirect queue and all valid outputs.
- R7: No fetch is issued on an edge where `imem_req_ready` or `fd_ready` is low, and the program counter then holds its value.
- R8: `res_commit` rises one cycle after a resolution whose epoch matches, and only then. It is never high together with `res_drop`. It is the sole permission for a resolved instruction to write registers or memory.
- R9: The redirect queue is never written while it already holds an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_req_ready | input | 1 | Instruction memory can take a request this cycle |
| imem_req_valid | output | 1 | Registered fetch request strobe |
| imem_req_addr | output | AW | Fetch request address |
| fd_ready | input | 1 | Fetch-to-decode queue has a free slot this cycle |
| fd_valid | output | 1 | Tag for decode is valid |
| fd_pc | output | AW | Address of the fetched instruction |
| fd_pred_pc | output | AW | Guessed successor address |
| fd_epoch | output | 1 | Fetch epoch of this instruction |
| res_valid | input | 1 | Execute presents a resolved instruction |
| res_epoch | input | 1 | Epoch tag the instruction carried |
| res_pred_pc | input | AW | Successor guessed at fetch |
| res_next_pc | input | AW | Successor computed by execute |
| res_commit | output | 1 | Resolved instruction may update state |
| res_drop | output | 1 | Resolved instruction was discarded |
| res_mispredict | output | 1 | Resolved instruction caused a redirect |

## Verification
Several rules are checked on every cycle. Back-to-back issues must follow a step of 4, and each issue's guess must be its own address plus 4. A full redirect queue must empty on the next edge and leave a bubble, a stalled edge must issue nothing, and commit and drop must be mutually exclusive. The queue must never be written while full, and every redirect push must flip the execute epoch. Only the bench's scenarios can show that the fetch address actually lands on the redirect target with an inverted epoch. The same holds for wrong-path resolutions leaving the fetch stream untouched, and for the exact cycle in which each outcome appears.

// File: rtl/fru_pkg.sv
package fru_pkg;
  localparam int unsigned FRU_INSTR_BYTES = 4;

  typedef enum logic [1:0] {
    RES_IDLE   = 2'd0,
    RES_COMMIT = 2'd1,
    RES_DROP   = 2'd2
  } res_kind_e;
endpackage

// File: rtl/fru_redirect_q.sv
module fru_redirect_q #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_pc,
  input  logic          pop,
  output logic          full,
  output logic [AW-1:0] head_pc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full    <= 1'b0;
      head_pc <= '0;
    end else if (push) begin
      full    <= 1'b1;
      head_pc <= push_pc;
    end else if (pop) begin
      full    <= 1'b0;
    end
  end
endmodule

// File: rtl/fru_fetch_ctl.sv
module fru_fetch_ctl #(
  parameter int unsigned AW       = 32,
  parameter int unsigned STEP     = 4,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          imem_ready,
  input  logic          dec_ready,
  input  logic          redir_full,
  input  logic [AW-1:0] redir_pc,
  output logic          redir_pop,
  output logic          iss_valid,
  output logic [AW-1:0] iss_pc,
  output logic [AW-1:0] iss_pred,
  output logic          iss_epoch
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  logic [AW-1:0] pc_q;
  logic          epoch_q;
  logic          issue;

  assign redir_pop = redir_full;
  assign issue     = !redir_full && imem_ready && dec_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= RESET_PC;
      epoch_q   <= 1'b0;
      iss_valid <= 1'b0;
      iss_pc    <= '0;
      iss_pred  <= '0;
      iss_epoch <= 1'b0;
    end else begin
      iss_valid <= issue;
      if (redir_full) begin
        pc_q    <= redir_pc;
        epoch_q <= ~epoch_q;
      end else if (issue) begin
        iss_pc    <= pc_q;
        iss_pred  <= pc_q + STEP_V;
        iss_epoch <= epoch_q;
        pc_q      <= pc_q + STEP_V;
      end
    end
  end
endmodule

// File: rtl/fru_exec_check.sv
module fru_exec_check
  import fru_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_epoch,
  input  logic [AW-1:0] in_pred,
  input  logic [AW-1:0] in_next,
  output logic          push,
  output logic [AW-1:0] push_pc,
  output logic          epoch,
  output logic          commit,
  output logic          drop,
  output logic          mispredict
);
  logic      same_epoch;
  res_kind_e kind;

  assign same_epoch = in_valid && (in_epoch == epoch);
  assign push       = same_epoch && (in_next != in_pred);
  assign push_pc    = in_next;

  always_comb begin
    if (!in_valid)       kind = RES_IDLE;
    else if (same_epoch) kind = RES_COMMIT;
    else                 kind = RES_DROP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      epoch      <= 1'b0;
      commit     <= 1'b0;
      drop       <= 1'b0;
      mispredict <= 1'b0;
    end else begin
      commit     <= (kind == RES_COMMIT);
      drop       <= (kind == RES_DROP);
      mispredict <= push;
      if (push) epoch <= ~epoch;
    end
  end
endmodule

// File: rtl/fetch_redirect_unit.sv
module fetch_redirect_unit #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          imem_req_ready,
  output logic          imem_req_valid,
  output logic [AW-1:0] imem_req_addr,
  input  logic          fd_ready,
  output logic          fd_valid,
  output logic [AW-1:0] fd_pc,
  output logic [AW-1:0] fd_pred_pc,
  output logic          fd_epoch,
  input  logic          res_valid,
  input  logic          res_epoch,
  input  logic [AW-1:0] res_pred_pc,
  input  logic [AW-1:0] res_next_pc,
  output logic          res_commit,
  output logic          res_drop,
  output logic          res_mispredict
);
  logic          redir_push;
  logic [AW-1:0] redir_push_pc;
  logic          redir_pop;
  logic          redir_full;
  logic [AW-1:0] redir_head;
  logic          exec_epoch;

  fru_redirect_q #(.AW(AW)) rq_i (
    .clk(clk), .rst(rst),
    .push(redir_push), .push_pc(redir_push_pc),
    .pop(redir_pop), .full(redir_full), .head_pc(redir_head)
  );

  fru_fetch_ctl #(.AW(AW), .STEP(fru_pkg::FRU_INSTR_BYTES)) fc_i (
    .clk(clk), .rst(rst),
    .imem_ready(imem_req_ready), .dec_ready(fd_ready),
    .redir_full(redir_full), .redir_pc(redir_head), .redir_pop(redir_pop),
    .iss_valid(fd_valid), .iss_pc(fd_pc), .iss_pred(fd_pred_pc),
    .iss_epoch(fd_epoch)
  );

  fru_exec_check #(.AW(AW)) ec_i (
    .clk(clk), .rst(rst),
    .in_valid(res_valid), .in_epoch(res_epoch),
    .in_pred(res_pred_pc), .in_next(res_next_pc),
    .push(redir_push), .push_pc(redir_push_pc), .epoch(exec_epoch),
    .commit(res_commit), .drop(res_drop), .mispredict(res_mispredict)
  );

  assign imem_req_valid = fd_valid;
  assign imem_req_addr  = fd_pc;
endmodule

// File: rtl/fru_checker.sv
module fru_checker #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          imem_req_ready,
  input logic          fd_ready,
  input logic          fd_valid,
  input logic [AW-1:0] fd_pc,
  input logic [AW-1:0] fd_pred_pc,
  input logic          fd_epoch,
  input logic          res_commit,
  input logic          res_drop,
  input logic          redir_full,
  input logic          redir_push,
  input logic          exec_epoch
);
  assert_seq_step_R1: assert property (@(posedge clk) disable iff (rst)
    fd_valid && $past(fd_valid) && (fd_epoch == $past(fd_epoch))
      |-> fd_pc == $past(fd_pred_pc));

  assert_pred_next_R2: assert property (@(posedge clk) disable iff (rst)
    fd_valid |-> fd_pred_pc == fd_pc + AW'(4));

  assert_epoch_flip_R4: assert property (@(posedge clk) disable iff (rst)
    redir_push |=> exec_epoch != $past(exec_epoch));

  assert_redir_bubble_R5: assert property (@(posedge clk) disable iff (rst)
    redir_full |=> !fd_valid && !redir_full);

  assert_clean_start_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !fd_valid && !redir_full && !res_commit && !res_drop);

  assert_stall_R7: assert property (@(posedge clk) disable iff (rst)
    !(imem_req_ready && fd_ready) |=> !fd_valid);

  assert_commit_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(res_commit && res_drop));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    redir_full |-> !redir_push);
endmodule

bind fetch_redirect_unit fru_checker #(.AW(AW)) chk_i (
  .clk(clk), .rst(rst),
  .imem_req_ready(imem_req_ready), .fd_ready(fd_ready),
  .fd_valid(fd_valid), .fd_pc(fd_pc), .fd_pred_pc(fd_pred_pc),
  .fd_epoch(fd_epoch), .res_commit(res_commit), .res_drop(res_drop),
  .redir_full(redir_full), .redir_push(redir_push), .exec_epoch(exec_epoch)
);

// File: tb/fetch_redirect_unit_tb.sv
module fetch_redirect_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  // {epoch, pred, next, expect_commit, expect_mispredict}
  localparam logic [66:0] VEC [0:7] = '{
    {1'b0, 32'h10,  32'h10,  1'b1, 1'b0},
    {1'b1, 32'h20,  32'h20,  1'b0, 1'b0},
    {1'b0, 32'h14,  32'h40,  1'b1, 1'b1},
    {1'b0, 32'h04,  32'h08,  1'b0, 1'b0},
    {1'b1, 32'h44,  32'h44,  1'b1, 1'b0},
    {1'b1, 32'h48,  32'h100, 1'b1, 1'b1},
    {1'b1, 32'h50,  32'h60,  1'b0, 1'b0},
    {1'b0, 32'h70,  32'h70,  1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic imem_req_ready = 1'b0, fd_ready = 1'b0;
  logic imem_req_valid, fd_valid, fd_epoch;
  logic [AW-1:0] imem_req_addr, fd_pc, fd_pred_pc;
  logic res_valid = 1'b0, res_epoch = 1'b0;
  logic [AW-1:0] res_pred_pc = '0, res_next_pc = '0;
  logic res_commit, res_drop, res_mispredict;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_redirect_unit #(.AW(AW)) dut_i (
    .clk(clk), .rst(rst),
    .imem_req_ready(imem_req_ready), .imem_req_valid(imem_req_valid),
    .imem_req_addr(imem_req_addr), .fd_ready(fd_ready),
    .fd_valid(fd_valid), .fd_pc(fd_pc), .fd_pred_pc(fd_pred_pc),
    .fd_epoch(fd_epoch), .res_valid(res_valid), .res_epoch(res_epoch),
    .res_pred_pc(res_pred_pc), .res_next_pc(res_next_pc),
    .res_commit(res_commit), .res_drop(res_drop),
    .res_mispredict(res_mispredict)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_issue(input string req, input logic [AW-1:0] pc, input logic ep);
    chk(req, {31'd0, fd_valid}, 1);
    chk(req, {31'd0, imem_req_valid}, 1);
    chk(req, fd_pc, pc);
    chk(req, imem_req_addr, pc);
    chk(req, fd_pred_pc, pc + 4);
    chk(req, {31'd0, fd_epoch}, {31'd0, ep});
  endtask

  task automatic resolve(input logic ep, input logic [AW-1:0] pred, input logic [AW-1:0] nxt);
    res_valid = 1'b1; res_epoch = ep; res_pred_pc = pred; res_next_pc = nxt;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R6 reset fd_valid", {31'd0, fd_valid}, 0);
    chk("R6 reset commit", {31'd0, res_commit}, 0);
    chk("R6 reset drop", {31'd0, res_drop}, 0);
    rst = 1'b0;
    imem_req_ready = 1'b1; fd_ready = 1'b1;

    // R1 R2: sequential not-taken stream from address 0
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk_issue("R1 R2 sequential", AW'(4 * i), 1'b0);
    end

    // R7: stalls
    imem_req_ready = 1'b0;
    @(negedge clk);
    chk("R7 imem stall", {31'd0, fd_valid}, 0);
    imem_req_ready = 1'b1; fd_ready = 1'b0;
    @(negedge clk);
    chk("R7 decode stall", {31'd0, fd_valid}, 0);
    fd_ready = 1'b1;
    @(negedge clk);
    chk_issue("R7 resume without skip", 32'hC, 1'b0);
    imem_req_ready = 1'b0; fd_ready = 1'b0;

    // R3 R4 R8: resolution table, fetch held off
    for (int i = 0; i < 8; i++) begin
      resolve(VEC[i][66], VEC[i][65:34], VEC[i][33:2]);
      @(negedge clk);
      res_valid = 1'b0;
      chk("R8 commit", {31'd0, res_commit}, {31'd0, VEC[i][1]});
      chk("R3 drop", {31'd0, res_drop}, {31'd0, ~VEC[i][1]});
      chk("R4 mispredict", {31'd0, res_mispredict}, {31'd0, VEC[i][0]});
      @(negedge clk);
    end

    // R5: two redirects happened while stalled; last target 0x100, epoch back to 0
    imem_req_ready = 1'b1; fd_ready = 1'b1;
    @(negedge clk);
    chk_issue("R5 target after stalled redirects", 32'h100, 1'b0);

    // R5: live redirect with bubble and flipped epoch
    resolve(1'b0, 32'h104, 32'h200);
    @(negedge clk);
    res_valid = 1'b0;
    chk_issue("R5 issue before redirect lands", 32'h104, 1'b0);
    chk("R4 live mispredict", {31'd0, res_mispredict}, 1);
    @(negedge clk);
    chk("R5 bubble on dequeue", {31'd0, fd_valid}, 0);
    @(negedge clk);
    chk_issue("R5 redirect target", 32'h200, 1'b1);

    // R3: wrong-path resolution with differing addresses changes nothing
    resolve(1'b0, 32'h108, 32'h300);
    @(negedge clk);
    res_valid = 1'b0;
    chk("R3 wrong path dropped", {31'd0, res_drop}, 1);
    chk("R3 wrong path no mispredict", {31'd0, res_mispredict}, 0);
    chk_issue("R3 stream continues", 32'h204, 1'b1);
    @(negedge clk);
    chk_issue("R3 no redirect", 32'h208, 1'b1);

    // R8: correct-path resolution commits
    resolve(1'b1, 32'h204, 32'h204);
    @(negedge clk);
    res_valid = 1'b0;
    chk("R8 matching commit", {31'd0, res_commit}, 1);
    chk("R4 no mispredict on match", {31'd0, res_mispredict}, 0);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule